// File: doc/BRIEF.md
# Frequency Synthesizer Configuration and Clock-Switch Controller

This block sits beside an analog frequency synthesizer and manages it. Software writes a multiplier, a post-divider and the reference frequency through a small register port. It also writes an enable request and a connect request. None of these values reach the synthesizer until a two-write feed sequence commits them. The block checks the staged settings against the legal operating windows. A commit that would enable the synthesizer with illegal settings is refused.

Once a commit is accepted, a sequencer enforces a fixed order. The synthesizer is enabled first. The block then waits for the synchronized lock indication. Only after lock may the core clock be switched away from the reference. If lock is lost while the synthesized clock drives the core, the block falls back to the reference clock on its own and raises a sticky interrupt flag. After reset the synthesizer is disabled and the core runs on the reference clock.

Top module: `synth_clk_ctrl`

## Requirements
- R1: After reset, `synth_en_o` is 0, `synth_bypass_o` is 1, `synth_mult_o` and `synth_div_o` are 0, and `seq_err_o` and `lock_irq_o` are 0.
- R2: Register writes go to staging registers. Address 0 is control: bit 0 is the enable request, bit 1 is the connect request, bit 2 clears the sequence error and bit 3 clears the interrupt. Address 1 is the setting: bits [4:0] hold the multiplier M minus one (M from 1 to 32), and bits [6:5] hold the post-divider code c, where P = 2^(c+1), giving 2, 4, 8 or 16. Address 2 holds the reference frequency in MHz. Address 3 is the feed register.
- R3: Staged values are committed only by writing 0xAA to address 3 with the very next register write being 0x55 to address 3. Any other write in between cancels the sequence.
- R4: `cfg_bad_o` is 0 only when all three windows hold for the staged values: the reference is within 10..25 MHz, ref×M is within 10..60 MHz, and ref×M×P is within 156..320 MHz.
- R5: A commit whose staged enable is 1 while `cfg_bad_o` is 1 is refused. The active setting and the sequencer state stay unchanged, and `seq_err_o` is set.
- R6: An accepted commit with enable 1 raises `synth_en_o` in the next cycle. `synth_bypass_o` stays 1 while the block waits for lock.
- R7: The lock input passes through a two-flop synchronizer. A commit with connect 1, made after synchronized lock has been seen, drives `synth_bypass_o` to 0 in the next cycle.
- R8: A commit with connect 1 while synchronized lock is low does not connect. `synth_bypass_o` stays 1 and the sticky `seq_err_o` is set.
- R9: If synchronized lock drops while connected, `synth_bypass_o` returns to 1, `lock_irq_o` is set, and `synth_en_o` stays 1.
- R10: An accepted commit with enable 0 drives `synth_en_o` to 0 and `synth_bypass_o` to 1, and it does not set `lock_irq_o`.
- R11: Writing a 1 to control bit 2 clears `seq_err_o`, and writing a 1 to control bit 3 clears `lock_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| lock_i | input | 1 | Asynchronous lock indication from the synthesizer |
| synth_en_o | output | 1 | Synthesizer enable |
| synth_bypass_o | output | 1 | 1: core runs on reference; 0: core runs on synthesized clock |
| synth_mult_o | output | 5 | Active multiplier code (M minus one) |
| synth_div_o | output | 2 | Active post-divider code |
| cfg_bad_o | output | 1 | Staged settings are outside the legal windows |
| seq_err_o | output | 1 | Sticky: refused commit or connect without lock |
| lock_irq_o | output | 1 | Sticky: lock was lost while connected |

## Verification
The assertions check several properties on every cycle. The active setting changes only on an accepted commit. The enable never rises after a commit of illegal settings. The switch to the synthesized clock happens only in the cycle after a commit that saw synchronized lock. A refused connect always sets the error flag. A lock-loss interrupt always coincides with a return to the reference clock. The window arithmetic at its exact edges (156, 320, 10 and 60 MHz) can only be shown by the bench's vector table. The same holds for the feed sequence being cancelled by an intervening write, and for the full enable, lock, connect, loss and disable scenario.

// File: rtl/synth_ctrl_pkg.sv
// Package: shared widths, register addresses, control bit positions,
// sequencer states and the staged-setting record.
// Assumes an 8-bit register data path.
package synth_ctrl_pkg;

    localparam int unsigned MULT_W = 5;
    localparam int unsigned DIV_W  = 2;
    localparam int unsigned REF_W  = 8;

    // Register addresses (the decode depends on them)
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_REF  = 2'd2;
    localparam logic [1:0] ADDR_FEED = 2'd3;

    // Control register bit positions
    localparam int unsigned CTRL_EN_BIT      = 0;
    localparam int unsigned CTRL_CONN_BIT    = 1;
    localparam int unsigned CTRL_CLR_ERR_BIT = 2;
    localparam int unsigned CTRL_CLR_IRQ_BIT = 3;

    // Setting register: multiplier code at the bottom, divider code above it
    localparam int unsigned CFG_DIV_LSB = MULT_W;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAIT_LOCK,
        ST_LOCKED,
        ST_CONNECTED
    } seq_state_e;

    typedef struct packed {
        logic [REF_W-1:0]  ref_mhz;
        logic [MULT_W-1:0] mult_code;
        logic [DIV_W-1:0]  div_code;
        logic              en;
        logic              connect;
    } synth_cfg_t;

endpackage

// File: rtl/synth_lock_sync.sv
// Module: multi-flop synchronizer for the asynchronous lock indication.
// Assumes STAGES >= 2; the output lags the input by STAGES clock edges.
module synth_lock_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/synth_range_chk.sv
// Module: combinational window check of a setting.
// The output frequency is ref*M and the core frequency is ref*M*P,
// with M = code+1 and P = 2^(code+1). All frequencies are whole MHz.
module synth_range_chk
    import synth_ctrl_pkg::*;
#(
    parameter int unsigned REF_MIN = 10,
    parameter int unsigned REF_MAX = 25,
    parameter int unsigned OUT_MIN = 10,
    parameter int unsigned OUT_MAX = 60,
    parameter int unsigned CCO_MIN = 156,
    parameter int unsigned CCO_MAX = 320
) (
    input  logic [REF_W-1:0]  ref_mhz_i,
    input  logic [MULT_W-1:0] mult_code_i,
    input  logic [DIV_W-1:0]  div_code_i,
    output logic              valid_o
);

    localparam int unsigned OUT_W = REF_W + MULT_W + 1;
    localparam int unsigned CCO_W = OUT_W + (1 << DIV_W);

    logic [MULT_W:0]  mult_val;
    logic [DIV_W:0]   shamt;
    logic [OUT_W-1:0] out_mhz;
    logic [CCO_W-1:0] cco_mhz;
    logic             ref_ok, out_ok, cco_ok;

    // Derive output and core frequencies, then compare each with its window
    always_comb begin
        mult_val = {1'b0, mult_code_i} + {{MULT_W{1'b0}}, 1'b1};
        shamt    = {1'b0, div_code_i} + {{DIV_W{1'b0}}, 1'b1};
        out_mhz  = OUT_W'(ref_mhz_i) * OUT_W'(mult_val);
        cco_mhz  = CCO_W'(out_mhz) << shamt;
        ref_ok   = (ref_mhz_i >= REF_W'(REF_MIN)) && (ref_mhz_i <= REF_W'(REF_MAX));
        out_ok   = (out_mhz >= OUT_W'(OUT_MIN)) && (out_mhz <= OUT_W'(OUT_MAX));
        cco_ok   = (cco_mhz >= CCO_W'(CCO_MIN)) && (cco_mhz <= CCO_W'(CCO_MAX));
        valid_o  = ref_ok && out_ok && cco_ok;
    end

endmodule

// File: rtl/synth_cfg_regs.sv
// Module: staging registers, the two-write feed detector and the active
// setting. A commit pulse is raised by the feed detector; the active copy
// loads only when the parent confirms with commit_ok_i in the same cycle.
module synth_cfg_regs
    import synth_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned REF_RST = 12,
    parameter logic [7:0]  KEY_A   = 8'hAA,
    parameter logic [7:0]  KEY_B   = 8'h55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              commit_ok_i,
    output synth_cfg_t        pend_o,
    output logic [MULT_W-1:0] act_mult_o,
    output logic [DIV_W-1:0]  act_div_o,
    output logic              feed_done_o,
    output logic              clr_err_o,
    output logic              clr_irq_o
);

    synth_cfg_t        pend_q;
    logic [MULT_W-1:0] act_mult_q;
    logic [DIV_W-1:0]  act_div_q;
    logic              armed_q;
    logic              is_feed, is_ctrl;

    assign is_feed     = wr_en && (wr_addr == ADDR_FEED);
    assign is_ctrl     = wr_en && (wr_addr == ADDR_CTRL);
    assign feed_done_o = is_feed && armed_q && (wr_data[7:0] == KEY_B);
    assign clr_err_o   = is_ctrl && wr_data[CTRL_CLR_ERR_BIT];
    assign clr_irq_o   = is_ctrl && wr_data[CTRL_CLR_IRQ_BIT];

    // Arm on the first key; any following write disarms or completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_en) begin
            armed_q <= is_feed && (wr_data[7:0] == KEY_A);
        end
    end

    // Capture software writes into the staging registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q.ref_mhz   <= REF_W'(REF_RST);
            pend_q.mult_code <= '0;
            pend_q.div_code  <= '0;
            pend_q.en        <= 1'b0;
            pend_q.connect   <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: begin
                    pend_q.en      <= wr_data[CTRL_EN_BIT];
                    pend_q.connect <= wr_data[CTRL_CONN_BIT];
                end
                ADDR_CFG: begin
                    pend_q.mult_code <= wr_data[MULT_W-1:0];
                    pend_q.div_code  <= wr_data[CFG_DIV_LSB +: DIV_W];
                end
                ADDR_REF: pend_q.ref_mhz <= wr_data[REF_W-1:0];
                default: ;
            endcase
        end
    end

    // Load the active setting on an accepted commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_mult_q <= '0;
            act_div_q  <= '0;
        end else if (commit_ok_i) begin
            act_mult_q <= pend_q.mult_code;
            act_div_q  <= pend_q.div_code;
        end
    end

    assign pend_o     = pend_q;
    assign act_mult_o = act_mult_q;
    assign act_div_o  = act_div_q;

    // R3: the active setting holds unless a commit was accepted
    a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_ok_i |=> ($stable(act_mult_q) && $stable(act_div_q)));

    // R3: a commit is accepted only while a feed is in progress
    a_r3_commit_from_feed: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ok_i |-> (is_feed && armed_q));

endmodule

// File: rtl/synth_seq.sv
// Module: enable / lock-wait / connect sequencer with lock-loss fallback
// and the two sticky status flags. Commits are single-cycle events;
// lock_s_i is the already synchronized lock.
module synth_seq
    import synth_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_s_i,
    input  logic commit_ok_i,
    input  logic feed_rej_i,
    input  logic req_en_i,
    input  logic req_conn_i,
    input  logic clr_err_i,
    input  logic clr_irq_i,
    output logic synth_en_o,
    output logic bypass_o,
    output logic seq_err_o,
    output logic lock_irq_o
);

    seq_state_e state_q, state_d;
    logic       conn_bad, lost;
    logic       err_q, irq_q;

    // Next state from commit events and lock transitions
    always_comb begin
        state_d  = state_q;
        conn_bad = 1'b0;
        lost     = 1'b0;
        if (commit_ok_i) begin
            if (!req_en_i) begin
                state_d = ST_OFF;
            end else begin
                case (state_q)
                    ST_OFF: begin
                        state_d  = ST_WAIT_LOCK;
                        conn_bad = req_conn_i;
                    end
                    ST_WAIT_LOCK: conn_bad = req_conn_i;
                    ST_LOCKED: begin
                        if (!lock_s_i) begin
                            state_d  = ST_WAIT_LOCK;
                            conn_bad = req_conn_i;
                        end else if (req_conn_i) begin
                            state_d = ST_CONNECTED;
                        end
                    end
                    ST_CONNECTED: begin
                        if (!lock_s_i) begin
                            state_d  = ST_WAIT_LOCK;
                            lost     = 1'b1;
                            conn_bad = req_conn_i;
                        end else if (!req_conn_i) begin
                            state_d = ST_LOCKED;
                        end
                    end
                    default: state_d = ST_OFF;
                endcase
            end
        end else begin
            case (state_q)
                ST_WAIT_LOCK: if (lock_s_i) state_d = ST_LOCKED;
                ST_LOCKED:    if (!lock_s_i) state_d = ST_WAIT_LOCK;
                ST_CONNECTED: begin
                    if (!lock_s_i) begin
                        state_d = ST_WAIT_LOCK;
                        lost    = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Sticky flags: setting wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (feed_rej_i || conn_bad) err_q <= 1'b1;
            else if (clr_err_i)         err_q <= 1'b0;
            if (lost)                   irq_q <= 1'b1;
            else if (clr_irq_i)         irq_q <= 1'b0;
        end
    end

    assign synth_en_o = (state_q != ST_OFF);
    assign bypass_o   = (state_q != ST_CONNECTED);
    assign seq_err_o  = err_q;
    assign lock_irq_o = irq_q;

    // R7: leaving bypass needs a commit that saw synchronized lock
    a_r7_connect_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bypass_o) |-> ($past(lock_s_i) && $past(commit_ok_i)));

    // R8: a connect commit without lock always sets the error flag
    a_r8_conn_no_lock_err: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ok_i && req_en_i && req_conn_i && !lock_s_i) |=> (seq_err_o && bypass_o));

    // R9: the interrupt rises only when the connected clock is dropped
    a_r9_loss_falls_back: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_irq_o) |-> (bypass_o && synth_en_o && !$past(bypass_o)));

    // R10: a disabling commit powers down and bypasses
    a_r10_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_ok_i && !req_en_i) |=> (!synth_en_o && bypass_o));

endmodule

// File: rtl/synth_clk_ctrl.sv
// Module: top of the frequency synthesizer controller. It ties together
// the staging registers, the window check, the lock synchronizer and the
// sequencer. It decides whether a completed feed is accepted or refused.
// Assumes one clock domain (the reference clock) and an asynchronous lock input.
module synth_clk_ctrl
    import synth_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned REF_RST     = 12,
    parameter int unsigned REF_MIN     = 10,
    parameter int unsigned REF_MAX     = 25,
    parameter int unsigned OUT_MIN     = 10,
    parameter int unsigned OUT_MAX     = 60,
    parameter int unsigned CCO_MIN     = 156,
    parameter int unsigned CCO_MAX     = 320
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock_i,
    output logic              synth_en_o,
    output logic              synth_bypass_o,
    output logic [MULT_W-1:0] synth_mult_o,
    output logic [DIV_W-1:0]  synth_div_o,
    output logic              cfg_bad_o,
    output logic              seq_err_o,
    output logic              lock_irq_o
);

    synth_cfg_t pend;
    logic       pend_valid, feed_done, commit_ok, feed_rej;
    logic       clr_err, clr_irq, lock_s;

    // Refuse a feed that would enable with illegal settings
    assign feed_rej  = feed_done && pend.en && !pend_valid;
    assign commit_ok = feed_done && !feed_rej;
    assign cfg_bad_o = !pend_valid;

    synth_cfg_regs #(
        .DATA_W  (DATA_W),
        .REF_RST (REF_RST)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .commit_ok_i (commit_ok),
        .pend_o      (pend),
        .act_mult_o  (synth_mult_o),
        .act_div_o   (synth_div_o),
        .feed_done_o (feed_done),
        .clr_err_o   (clr_err),
        .clr_irq_o   (clr_irq)
    );

    synth_range_chk #(
        .REF_MIN (REF_MIN),
        .REF_MAX (REF_MAX),
        .OUT_MIN (OUT_MIN),
        .OUT_MAX (OUT_MAX),
        .CCO_MIN (CCO_MIN),
        .CCO_MAX (CCO_MAX)
    ) u_range (
        .ref_mhz_i   (pend.ref_mhz),
        .mult_code_i (pend.mult_code),
        .div_code_i  (pend.div_code),
        .valid_o     (pend_valid)
    );

    synth_lock_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (lock_i),
        .sync_o  (lock_s)
    );

    synth_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_s_i    (lock_s),
        .commit_ok_i (commit_ok),
        .feed_rej_i  (feed_rej),
        .req_en_i    (pend.en),
        .req_conn_i  (pend.connect),
        .clr_err_i   (clr_err),
        .clr_irq_i   (clr_irq),
        .synth_en_o  (synth_en_o),
        .bypass_o    (synth_bypass_o),
        .seq_err_o   (seq_err_o),
        .lock_irq_o  (lock_irq_o)
    );

    // R5: the enable never rises out of a commit of illegal settings
    a_r5_enable_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synth_en_o) |-> $past(pend_valid));

    // R5: a refused feed leaves the active setting untouched and flags it
    a_r5_refuse_flags: assert property (@(posedge clk) disable iff (!rst_n)
        feed_rej |=> (seq_err_o && $stable(synth_mult_o) && $stable(synth_div_o)));

endmodule

// File: tb/synth_clk_ctrl_bench.sv
// Bench: a vector table for the window check, then directed scenarios for
// the feed sequence, refusal, enable, lock wait, connect, lock loss,
// flag clearing and disable.
module synth_clk_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       lock_i = 1'b0;
    logic       synth_en_o, synth_bypass_o, cfg_bad_o, seq_err_o, lock_irq_o;
    logic [4:0] synth_mult_o;
    logic [1:0] synth_div_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    synth_clk_ctrl u_synth_clk_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .lock_i         (lock_i),
        .synth_en_o     (synth_en_o),
        .synth_bypass_o (synth_bypass_o),
        .synth_mult_o   (synth_mult_o),
        .synth_div_o    (synth_div_o),
        .cfg_bad_o      (cfg_bad_o),
        .seq_err_o      (seq_err_o),
        .lock_irq_o     (lock_irq_o)
    );

    // Vector: ref MHz [15:8], multiplier code [7:3], divider code [2:1], expected bad [0]
    localparam int NV = 14;
    localparam logic [15:0] VEC [0:NV-1] = '{
        {8'd12, 5'd4,  2'd1, 1'b0},   // out 60, core 240
        {8'd12, 5'd4,  2'd0, 1'b1},   // core 120 too low
        {8'd12, 5'd5,  2'd1, 1'b1},   // out 72 too high
        {8'd10, 5'd3,  2'd1, 1'b0},   // out 40, core 160
        {8'd9,  5'd3,  2'd2, 1'b1},   // reference too low
        {8'd25, 5'd1,  2'd1, 1'b0},   // out 50, core 200
        {8'd26, 5'd0,  2'd2, 1'b1},   // reference too high
        {8'd20, 5'd0,  2'd2, 1'b0},   // core 160
        {8'd20, 5'd0,  2'd3, 1'b0},   // core 320 upper edge
        {8'd10, 5'd0,  2'd3, 1'b0},   // out 10 lower edge
        {8'd13, 5'd0,  2'd2, 1'b1},   // core 104
        {8'd10, 5'd31, 2'd0, 1'b1},   // out 320
        {8'd13, 5'd2,  2'd1, 1'b0},   // core 156 lower edge
        {8'd21, 5'd0,  2'd3, 1'b1}    // core 336
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic feed();
        wr(2'd3, 8'hAA);
        wr(2'd3, 8'h55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 enable", {7'd0, synth_en_o}, 8'd0);
        chk("R1 bypass", {7'd0, synth_bypass_o}, 8'd1);
        chk("R1 mult", {3'd0, synth_mult_o}, 8'd0);
        chk("R1 div", {6'd0, synth_div_o}, 8'd0);
        chk("R1 flags", {6'd0, seq_err_o, lock_irq_o}, 8'd0);

        // R4 window table, R2 field positions
        for (int i = 0; i < NV; i++) begin
            wr(2'd2, VEC[i][15:8]);
            wr(2'd1, {1'b0, VEC[i][2:1], VEC[i][7:3]});
            chk("R4 vector", {7'd0, cfg_bad_o}, {7'd0, VEC[i][0]});
        end

        // R3 feed cancelled by an intervening write
        wr(2'd2, 8'd12);
        wr(2'd1, {1'b0, 2'd1, 5'd4});
        wr(2'd0, 8'h00);
        wr(2'd3, 8'hAA);
        wr(2'd2, 8'd12);
        wr(2'd3, 8'h55);
        chk("R3 no commit", {3'd0, synth_mult_o}, 8'd0);
        feed();
        chk("R3 commit mult", {3'd0, synth_mult_o}, 8'd4);
        chk("R3 commit div", {6'd0, synth_div_o}, 8'd1);
        chk("R10 stays off", {7'd0, synth_en_o}, 8'd0);

        // R5 refused enable with illegal settings
        wr(2'd1, {1'b0, 2'd0, 5'd4});
        chk("R4 staged bad", {7'd0, cfg_bad_o}, 8'd1);
        wr(2'd0, 8'h01);
        feed();
        chk("R5 not enabled", {7'd0, synth_en_o}, 8'd0);
        chk("R5 div unchanged", {6'd0, synth_div_o}, 8'd1);
        chk("R5 error set", {7'd0, seq_err_o}, 8'd1);
        wr(2'd0, 8'h05);
        chk("R11 error cleared", {7'd0, seq_err_o}, 8'd0);

        // R6 accepted enable, waiting for lock
        wr(2'd1, {1'b0, 2'd1, 5'd4});
        feed();
        chk("R6 enabled", {7'd0, synth_en_o}, 8'd1);
        chk("R6 still bypassed", {7'd0, synth_bypass_o}, 8'd1);

        // R8 connect without lock
        wr(2'd0, 8'h03);
        feed();
        chk("R8 bypass kept", {7'd0, synth_bypass_o}, 8'd1);
        chk("R8 error set", {7'd0, seq_err_o}, 8'd1);
        wr(2'd0, 8'h07);
        chk("R11 error cleared again", {7'd0, seq_err_o}, 8'd0);

        // R7 connect after lock
        lock_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 bypass before connect", {7'd0, synth_bypass_o}, 8'd1);
        feed();
        chk("R7 connected", {7'd0, synth_bypass_o}, 8'd0);
        chk("R7 no error", {7'd0, seq_err_o}, 8'd0);

        // R9 lock loss while connected
        lock_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 fallback", {7'd0, synth_bypass_o}, 8'd1);
        chk("R9 irq", {7'd0, lock_irq_o}, 8'd1);
        chk("R9 still enabled", {7'd0, synth_en_o}, 8'd1);
        wr(2'd0, 8'h0B);
        chk("R11 irq cleared", {7'd0, lock_irq_o}, 8'd0);

        // R10 disable from the connected state
        lock_i = 1'b1;
        repeat (4) @(negedge clk);
        feed();
        chk("R7 reconnected", {7'd0, synth_bypass_o}, 8'd0);
        wr(2'd0, 8'h00);
        feed();
        chk("R10 disabled", {7'd0, synth_en_o}, 8'd0);
        chk("R10 bypassed", {7'd0, synth_bypass_o}, 8'd1);
        chk("R10 no irq", {7'd0, lock_irq_o}, 8'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule